// File: doc/BRIEF.md
# Two-Processor Peripheral Clock Gate

This block computes the clock enables for a group of peripherals that two processors share. Each processor has its own pair of bit sets, one bit per peripheral in each: an allocation bit that claims the peripheral for that processor, and a low-power bit that lets the peripheral keep its clock while that processor sleeps. Peripherals in the always-on domain also have a shared autonomous bit. With this bit set, such a peripheral keeps its clock when no processor needs it, as long as the always-on domain reports itself active.

Each processor reports its state as run, sleep or stop. A peripheral's clock enable is the OR of the contributions from every processor that has allocated it. Some peripherals are allocated by default when reset ends. One peripheral is tied to both processors and can never be released. The block also produces one power-down permission per switchable domain. The permission for a domain is withheld while the processor of the other domain is still powered and has allocated any peripheral inside the first domain.

Each processor writes through its own port, and one read port returns either processor's bit sets. All outputs come from registers. With default parameters there are eight peripherals: bits 0-2 are in domain 1, bits 3-5 are in domain 2, and bits 6-7 are in the always-on domain.

Top module: `dual_cpu_clk_gate`

## Requirements
- R1: A write on the processor-1 port changes only processor 1's bit sets, and a write on the processor-2 port changes only processor 2's bit sets. The write select is encoded as 0 = allocation set, 1 = low-power set, 2 = autonomous set, 3 = no effect.
- R2: When reset ends, processor 1's allocation set is 0x03 plus the permanent bit (0x83). Processor 2's allocation set is 0x08 plus the permanent bit (0x88). Both low-power sets are all ones, and the autonomous set is zero.
- R3: Bit 7, the permanent peripheral, always reads back as 1 in both allocation sets. A write cannot clear it.
- R4: State codes are 0 = run, 1 = sleep, 2 = stop, and 3 = stop. A processor in run contributes its allocation bits. A processor in sleep contributes its allocation bits ANDed with its low-power bits. A processor in stop contributes nothing.
- R5: A peripheral's enable is the OR of both processors' contributions. A peripheral allocated by both processors stays enabled while either of them runs, and it is disabled when both are in stop.
- R6: Autonomous bits are stored only for bits 6 and 7, and writes to the other bits are ignored. A stored autonomous bit enables its peripheral only while `aon_active` is 1.
- R7: If both ports write the autonomous set in the same cycle, the processor-1 data is stored.
- R8: `dom1_off_ok` is 0 exactly when `dom2_on` is 1 and processor 2 has allocated any of bits 0-2. `dom2_off_ok` is 0 exactly when `dom1_on` is 1 and processor 1 has allocated any of bits 3-5.
- R9: Every output is registered. A change to an input or a bit set appears on the outputs at the next clock edge. While reset is held, every output is 0.
- R10: `rd_sel` selects the read data combinationally: 0 = processor-1 allocation, 1 = processor-1 low-power, 2 = processor-2 allocation, 3 = processor-2 low-power, 4 = autonomous set. Any other code reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| c1_wr_en | input | 1 | Processor-1 write strobe |
| c1_wr_sel | input | 2 | Processor-1 target set |
| c1_wr_data | input | NP | Processor-1 write data |
| c2_wr_en | input | 1 | Processor-2 write strobe |
| c2_wr_sel | input | 2 | Processor-2 target set |
| c2_wr_data | input | NP | Processor-2 write data |
| rd_sel | input | 3 | Read select |
| rd_data | output | NP | Read data |
| c1_state | input | 2 | Processor-1 state code |
| c2_state | input | 2 | Processor-2 state code |
| aon_active | input | 1 | Always-on domain active |
| dom1_on | input | 1 | Domain 1 (processor 1) powered |
| dom2_on | input | 1 | Domain 2 (processor 2) powered |
| periph_clk_en | output | NP | Registered clock enable per peripheral |
| dom1_off_ok | output | 1 | Domain 1 may be switched off |
| dom2_off_ok | output | 1 | Domain 2 may be switched off |

## Verification
The hardest situations to reach are the ones where several conditions have to line up at once. One is a shared peripheral whose clock must survive while one processor stops and the other runs. Another is a sleep state masked bit by bit through the low-power set. A third is a domain veto that disappears when the other domain loses power. To reach them, the stimulus loads full configurations through both write ports one set at a time, then applies a pair of processor states and the power inputs. It checks the enables and permissions two edges later. Each vector pairs a configuration with its expected outputs.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_STOP  = 2'd2,
    ST_RSVD  = 2'd3
  } cpu_state_e;

  localparam logic [1:0] SEL_ALLOC = 2'd0;
  localparam logic [1:0] SEL_LOWP  = 2'd1;
  localparam logic [1:0] SEL_AUTO  = 2'd2;

  // One processor's vote for one peripheral clock.
  function automatic logic cpu_vote(logic alloc, logic lowp, logic [1:0] st);
    logic v;
    case (st)
      ST_RUN:   v = alloc;
      ST_SLEEP: v = alloc & lowp;
      default:  v = 1'b0;
    endcase
    return v;
  endfunction

  // True when the other powered domain holds any peripheral inside a mask.
  function automatic logic held_by_other(logic other_on, logic [63:0] claims);
    return other_on & (|claims);
  endfunction

endpackage

// File: rtl/pcg_cpu_regset.sv
module pcg_cpu_regset
  import pcg_pkg::*;
#(
  parameter int             NP        = 8,
  parameter logic [NP-1:0]  RST_ALLOC = '0,
  parameter logic [NP-1:0]  FIXED     = '0,
  parameter logic [NP-1:0]  RST_LOWP  = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [NP-1:0] wr_data,
  output logic [NP-1:0] alloc,
  output logic [NP-1:0] lowp
);

  logic [NP-1:0] alloc_q;
  logic [NP-1:0] lowp_q;
  logic          hit_alloc;
  logic          hit_lowp;

  assign hit_alloc = wr_en && (wr_sel == SEL_ALLOC);
  assign hit_lowp  = wr_en && (wr_sel == SEL_LOWP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_q <= RST_ALLOC | FIXED;
      lowp_q  <= RST_LOWP;
    end else begin
      if (hit_alloc) alloc_q <= wr_data | FIXED;
      if (hit_lowp)  lowp_q  <= wr_data;
    end
  end

  assign alloc = alloc_q;
  assign lowp  = lowp_q;

endmodule

// File: rtl/pcg_gate_cell.sv
module pcg_gate_cell
  import pcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a1,
  input  logic       l1,
  input  logic [1:0] s1,
  input  logic       a2,
  input  logic       l2,
  input  logic [1:0] s2,
  input  logic       auto_req,
  output logic       v1,
  output logic       v2,
  output logic       en
);

  logic en_q;

  assign v1 = cpu_vote(a1, l1, s1);
  assign v2 = cpu_vote(a2, l2, s2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= v1 | v2 | auto_req;
  end

  assign en = en_q;

endmodule

// File: rtl/pcg_domain_veto.sv
module pcg_domain_veto
  import pcg_pkg::*;
#(
  parameter int            NP        = 8,
  parameter logic [NP-1:0] DOM1_MASK = '0,
  parameter logic [NP-1:0] DOM2_MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] alloc1,
  input  logic [NP-1:0] alloc2,
  input  logic          dom1_on,
  input  logic          dom2_on,
  output logic          dom1_claimed,
  output logic          dom2_claimed,
  output logic          dom1_off_ok,
  output logic          dom2_off_ok
);

  logic [63:0] c2_in_d1;
  logic [63:0] c1_in_d2;
  logic        ok1_q;
  logic        ok2_q;

  always_comb begin
    c2_in_d1 = '0;
    c1_in_d2 = '0;
    c2_in_d1[NP-1:0] = alloc2 & DOM1_MASK;
    c1_in_d2[NP-1:0] = alloc1 & DOM2_MASK;
  end

  assign dom1_claimed = held_by_other(dom2_on, c2_in_d1);
  assign dom2_claimed = held_by_other(dom1_on, c1_in_d2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok1_q <= 1'b0;
      ok2_q <= 1'b0;
    end else begin
      ok1_q <= !dom1_claimed;
      ok2_q <= !dom2_claimed;
    end
  end

  assign dom1_off_ok = ok1_q;
  assign dom2_off_ok = ok2_q;

endmodule

// File: rtl/dual_cpu_clk_gate.sv
module dual_cpu_clk_gate
  import pcg_pkg::*;
#(
  parameter int            NP         = 8,
  parameter logic [NP-1:0] RST_ALLOC1 = 8'h03,
  parameter logic [NP-1:0] RST_ALLOC2 = 8'h08,
  parameter logic [NP-1:0] FIXED_BOTH = 8'h80,
  parameter logic [NP-1:0] DOM1_MASK  = 8'h07,
  parameter logic [NP-1:0] DOM2_MASK  = 8'h38,
  parameter logic [NP-1:0] AON_MASK   = 8'hC0,
  parameter logic [NP-1:0] RST_LOWP   = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          c1_wr_en,
  input  logic [1:0]    c1_wr_sel,
  input  logic [NP-1:0] c1_wr_data,
  input  logic          c2_wr_en,
  input  logic [1:0]    c2_wr_sel,
  input  logic [NP-1:0] c2_wr_data,
  input  logic [2:0]    rd_sel,
  output logic [NP-1:0] rd_data,
  input  logic [1:0]    c1_state,
  input  logic [1:0]    c2_state,
  input  logic          aon_active,
  input  logic          dom1_on,
  input  logic          dom2_on,
  output logic [NP-1:0] periph_clk_en,
  output logic          dom1_off_ok,
  output logic          dom2_off_ok
);

  logic [NP-1:0] alloc1, lowp1, alloc2, lowp2;
  logic [NP-1:0] auto_q;
  logic [NP-1:0] auto_req;
  logic [NP-1:0] c1_vote, c2_vote;
  logic          dom1_claimed, dom2_claimed;
  logic          c1_auto_wr, c2_auto_wr;

  pcg_cpu_regset #(.NP(NP), .RST_ALLOC(RST_ALLOC1), .FIXED(FIXED_BOTH), .RST_LOWP(RST_LOWP))
  u_regs1 (
    .clk(clk), .rst_n(rst_n), .wr_en(c1_wr_en), .wr_sel(c1_wr_sel),
    .wr_data(c1_wr_data), .alloc(alloc1), .lowp(lowp1)
  );

  pcg_cpu_regset #(.NP(NP), .RST_ALLOC(RST_ALLOC2), .FIXED(FIXED_BOTH), .RST_LOWP(RST_LOWP))
  u_regs2 (
    .clk(clk), .rst_n(rst_n), .wr_en(c2_wr_en), .wr_sel(c2_wr_sel),
    .wr_data(c2_wr_data), .alloc(alloc2), .lowp(lowp2)
  );

  // Shared autonomous set: processor 1 takes priority on a collision.
  assign c1_auto_wr = c1_wr_en && (c1_wr_sel == SEL_AUTO);
  assign c2_auto_wr = c2_wr_en && (c2_wr_sel == SEL_AUTO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          auto_q <= '0;
    else if (c1_auto_wr) auto_q <= c1_wr_data & AON_MASK;
    else if (c2_auto_wr) auto_q <= c2_wr_data & AON_MASK;
  end

  assign auto_req = auto_q & {NP{aon_active}};

  for (genvar p = 0; p < NP; p++) begin : g_cell
    pcg_gate_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .a1(alloc1[p]), .l1(lowp1[p]), .s1(c1_state),
      .a2(alloc2[p]), .l2(lowp2[p]), .s2(c2_state),
      .auto_req(auto_req[p]),
      .v1(c1_vote[p]), .v2(c2_vote[p]), .en(periph_clk_en[p])
    );
  end

  pcg_domain_veto #(.NP(NP), .DOM1_MASK(DOM1_MASK), .DOM2_MASK(DOM2_MASK)) u_veto (
    .clk(clk), .rst_n(rst_n), .alloc1(alloc1), .alloc2(alloc2),
    .dom1_on(dom1_on), .dom2_on(dom2_on),
    .dom1_claimed(dom1_claimed), .dom2_claimed(dom2_claimed),
    .dom1_off_ok(dom1_off_ok), .dom2_off_ok(dom2_off_ok)
  );

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = alloc1;
      3'd1:    rd_data = lowp1;
      3'd2:    rd_data = alloc2;
      3'd3:    rd_data = lowp2;
      3'd4:    rd_data = auto_q;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/pcg_chk.sv
module pcg_chk #(
  parameter int            NP         = 8,
  parameter logic [NP-1:0] FIXED_BOTH = 8'h80,
  parameter logic [NP-1:0] DOM1_MASK  = 8'h07,
  parameter logic [NP-1:0] DOM2_MASK  = 8'h38
) (
  input logic          clk,
  input logic          rst_n,
  input logic          c2_wr_en,
  input logic [2:0]    rd_sel,
  input logic [NP-1:0] rd_data,
  input logic [1:0]    c1_state,
  input logic [1:0]    c2_state,
  input logic          aon_active,
  input logic          dom1_on,
  input logic          dom2_on,
  input logic [NP-1:0] alloc1,
  input logic [NP-1:0] alloc2,
  input logic [NP-1:0] lowp2,
  input logic [NP-1:0] periph_clk_en,
  input logic          dom1_off_ok,
  input logic          dom2_off_ok
);

  // R5
  both_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_state[1] && c2_state[1] && !aon_active) |=> (periph_clk_en == '0));

  // R4
  run_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_state == 2'd0) |=> ((periph_clk_en & $past(alloc1)) == $past(alloc1)));

  // R1
  c2_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c2_wr_en |=> ($stable(alloc2) && $stable(lowp2)));

  // R8
  dom1_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dom2_on && |(alloc2 & DOM1_MASK)) |=> !dom1_off_ok);

  // R8
  dom2_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dom1_on && |(alloc1 & DOM2_MASK)) |=> !dom2_off_ok);

  // R3
  fixed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 3'd0 || rd_sel == 3'd2) |-> ((rd_data & FIXED_BOTH) == FIXED_BOTH));

endmodule

bind dual_cpu_clk_gate pcg_chk #(
  .NP(NP), .FIXED_BOTH(FIXED_BOTH), .DOM1_MASK(DOM1_MASK), .DOM2_MASK(DOM2_MASK)
) u_pcg_chk (
  .clk(clk), .rst_n(rst_n), .c2_wr_en(c2_wr_en), .rd_sel(rd_sel), .rd_data(rd_data),
  .c1_state(c1_state), .c2_state(c2_state), .aon_active(aon_active),
  .dom1_on(dom1_on), .dom2_on(dom2_on), .alloc1(alloc1), .alloc2(alloc2),
  .lowp2(lowp2), .periph_clk_en(periph_clk_en),
  .dom1_off_ok(dom1_off_ok), .dom2_off_ok(dom2_off_ok)
);

// File: tb/tb_dual_cpu_clk_gate.sv
module tb_dual_cpu_clk_gate;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       c1_wr_en = 1'b0, c2_wr_en = 1'b0;
  logic [1:0] c1_wr_sel = 2'd3, c2_wr_sel = 2'd3;
  logic [7:0] c1_wr_data = '0, c2_wr_data = '0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic [1:0] c1_state = 2'd0, c2_state = 2'd0;
  logic       aon_active = 1'b0, dom1_on = 1'b1, dom2_on = 1'b1;
  logic [7:0] periph_clk_en;
  logic       dom1_off_ok, dom2_off_ok;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  dual_cpu_clk_gate dut (
    .clk(clk), .rst_n(rst_n),
    .c1_wr_en(c1_wr_en), .c1_wr_sel(c1_wr_sel), .c1_wr_data(c1_wr_data),
    .c2_wr_en(c2_wr_en), .c2_wr_sel(c2_wr_sel), .c2_wr_data(c2_wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .c1_state(c1_state), .c2_state(c2_state), .aon_active(aon_active),
    .dom1_on(dom1_on), .dom2_on(dom2_on),
    .periph_clk_en(periph_clk_en), .dom1_off_ok(dom1_off_ok), .dom2_off_ok(dom2_off_ok)
  );

  typedef struct packed {
    logic [7:0] e1, l1, e2, l2, au;
    logic [1:0] s1, s2;
    logic       aon, d1, d2;
    logic [7:0] x_clk;
    logic       x_ok1, x_ok2;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [0:NV-1] = '{
    '{8'h03, 8'hFF, 8'h08, 8'hFF, 8'h00, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 8'h8B, 1'b1, 1'b1},
    '{8'h03, 8'hFF, 8'h08, 8'hFF, 8'h00, 2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1},
    '{8'h0F, 8'hFF, 8'h30, 8'hFF, 8'h00, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 8'hB0, 1'b1, 1'b0},
    '{8'h04, 8'hFF, 8'h04, 8'hFF, 8'h00, 2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 8'h84, 1'b0, 1'b1},
    '{8'h04, 8'hFF, 8'h04, 8'hFF, 8'h00, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 8'h84, 1'b0, 1'b1},
    '{8'h21, 8'h01, 8'h00, 8'h00, 8'h00, 2'd1, 2'd2, 1'b0, 1'b1, 1'b1, 8'h01, 1'b1, 1'b0},
    '{8'h00, 8'hFF, 8'h00, 8'hFF, 8'hFF, 2'd2, 2'd2, 1'b1, 1'b1, 1'b1, 8'hC0, 1'b1, 1'b1},
    '{8'h00, 8'hFF, 8'h00, 8'hFF, 8'hFF, 2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1},
    '{8'h38, 8'hFF, 8'h07, 8'h00, 8'h00, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 8'hB8, 1'b1, 1'b1},
    '{8'h38, 8'hFF, 8'h07, 8'h00, 8'h00, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 8'hB8, 1'b0, 1'b0},
    '{8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h00, 2'd3, 2'd2, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic e1, input logic [1:0] s1, input logic [7:0] d1,
                    input logic e2, input logic [1:0] s2, input logic [7:0] d2);
    @(negedge clk);
    c1_wr_en = e1; c1_wr_sel = s1; c1_wr_data = d1;
    c2_wr_en = e2; c2_wr_sel = s2; c2_wr_data = d2;
    @(negedge clk);
    c1_wr_en = 1'b0; c2_wr_en = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic rd_check(input string req, input logic [2:0] sel, input logic [7:0] exp);
    rd_sel = sel; #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    // R9: outputs held at zero during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset clk_en", periph_clk_en, 8'h00);
    check("R9 reset ok", {6'd0, dom1_off_ok, dom2_off_ok}, 8'h00);
    rst_n = 1'b1;
    settle();
    // R2: default allocation, both running
    check("R2 default enables", periph_clk_en, 8'h8B);
    rd_check("R2 R3 R10 c1 alloc", 3'd0, 8'h83);
    rd_check("R2 R10 c1 lowp", 3'd1, 8'hFF);
    rd_check("R2 R3 R10 c2 alloc", 3'd2, 8'h88);
    rd_check("R2 R10 c2 lowp", 3'd3, 8'hFF);
    rd_check("R2 R10 auto", 3'd4, 8'h00);
    rd_check("R10 unused select", 3'd5, 8'h00);

    // Vector table: R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      wr(1'b1, 2'd0, v.e1, 1'b1, 2'd0, v.e2);
      wr(1'b1, 2'd1, v.l1, 1'b1, 2'd1, v.l2);
      wr(1'b1, 2'd2, v.au, 1'b0, 2'd3, 8'h00);
      c1_state = v.s1; c2_state = v.s2;
      aon_active = v.aon; dom1_on = v.d1; dom2_on = v.d2;
      settle();
      check($sformatf("R4 R5 R6 vector %0d clk_en", i), periph_clk_en, v.x_clk);
      check($sformatf("R8 vector %0d permits", i),
            {6'd0, dom1_off_ok, dom2_off_ok}, {6'd0, v.x_ok1, v.x_ok2});
    end

    // R1: one port cannot touch the other processor's sets
    wr(1'b0, 2'd0, 8'h00, 1'b1, 2'd0, 8'h12);
    wr(1'b1, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00);
    wr(1'b1, 2'd1, 8'h00, 1'b0, 2'd0, 8'h00);
    rd_check("R1 c2 alloc unchanged", 3'd2, 8'h92);
    rd_check("R1 c2 lowp unchanged", 3'd3, 8'hFF);
    rd_check("R3 c1 permanent bit kept", 3'd0, 8'h80);
    wr(1'b1, 2'd3, 8'hFF, 1'b1, 2'd3, 8'hFF);
    rd_check("R1 select 3 no effect", 3'd0, 8'h80);

    // R7: collision on the autonomous set
    wr(1'b1, 2'd2, 8'h40, 1'b1, 2'd2, 8'h80);
    rd_check("R7 processor 1 wins", 3'd4, 8'h40);
    wr(1'b0, 2'd0, 8'h00, 1'b1, 2'd2, 8'hFF);
    rd_check("R6 c2 auto write masked", 3'd4, 8'hC0);
    wr(1'b1, 2'd2, 8'h3F, 1'b0, 2'd0, 8'h00);
    rd_check("R6 non-always-on bits ignored", 3'd4, 8'h00);

    // R9: one-edge latency on a state change
    wr(1'b1, 2'd0, 8'h01, 1'b1, 2'd0, 8'h00);
    c1_state = 2'd0; c2_state = 2'd2; aon_active = 1'b0;
    settle();
    check("R9 before change", periph_clk_en, 8'h81);
    c1_state = 2'd2;
    #1;
    check("R9 held until edge", periph_clk_en, 8'h81);
    @(posedge clk); #1;
    check("R9 R4 after edge", periph_clk_en, 8'h00);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule